// File: doc/BRIEF.md
# Radio Packet Framer Transmitter

This block turns one radio packet into a serial bit stream, most significant bit first. A single start pulse launches the packet. The block then walks through its fields in a fixed order: an alternating preamble, a sync word of 4, 6 or 8 bytes, a 4-bit trailer, an optional header, an optional length byte, the payload, and an optional 16-bit CRC. Payload bytes come from a show-ahead byte FIFO. The block pops one byte per read pulse and uses the byte value present in the same cycle.

The bit rate is set from outside by a bit-rate enable. Each cycle in which that enable is high while a packet is in flight moves exactly one bit out. The bit appears on `tx_bit` together with a one-cycle `tx_valid` strobe in the following cycle. The configuration inputs are captured when the packet starts, so they may change freely while it is being sent. A one-cycle `done` pulse marks the end of the packet.

Top module: `pkt_framer_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `tx_valid`, `done` and `fifo_rd` are all 0.
- R2: Each cycle with `bit_en` high while busy emits exactly one bit. `tx_valid` is high for one cycle in the next cycle, with the bit on `tx_bit`. No bit is emitted while idle. The packet length in bits equals the sum of the enabled field lengths.
- R3: The preamble is 8*(`cfg_pre_len`+1) bits of alternating value. Its first bit is the inverse of `cfg_sync_word[63]`.
- R4: The sync word follows. `cfg_sync_len` code 0 selects 4 bytes, code 1 selects 6 bytes, and codes 2 and 3 select 8 bytes. The bits are sent from `cfg_sync_word[63]` downward.
- R5: The trailer is 4 alternating bits. Its first bit is the inverse of the last sync bit sent, `cfg_sync_word[64-8*bytes]`.
- R6: With `cfg_hdr_en`=1, the header byte {`cfg_pid`[1:0], `cfg_addr`[5:0]} is sent. With `cfg_addr_ext`=1, a second byte `cfg_addr`[13:6] follows it.
- R7: With `cfg_len_en`=1, one byte equal to `cfg_pay_len` is sent after the header.
- R8: `cfg_pay_len` payload bytes (0 to 255) follow. Each is fetched with a one-cycle `fifo_rd` pulse in the bit-enable cycle that emits the bit just before that byte's first bit, and `fifo_data` is taken in that cycle. With length 0, no read occurs.
- R9: With `cfg_crc_en`=1, a 16-bit CRC is sent high byte first. The CRC register is preset to 0xFFFF and updated MSB first over the header, length and payload bits. `cfg_crc_sel`=0 uses polynomial 0x1021 and `cfg_crc_sel`=1 uses 0x8005.
- R10: A start pulse during a packet is ignored. Configuration changes after the start do not alter the packet in flight.
- R11: `done` is a single-cycle pulse in the same cycle as the strobe of the last bit, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Packet launch request, accepted when idle |
| bit_en | input | 1 | Bit-rate enable, one bit per high cycle |
| cfg_pre_len | input | PRE_LEN_W | Preamble length in bytes minus one |
| cfg_sync_len | input | 2 | Sync length code (0:4, 1:6, 2/3:8 bytes) |
| cfg_sync_word | input | 64 | Sync word, sent from bit 63 down |
| cfg_hdr_en | input | 1 | Header enable |
| cfg_pid | input | 2 | Packet identifier, top bits of header byte |
| cfg_addr | input | 14 | Packet address |
| cfg_addr_ext | input | 1 | Send the extra address byte |
| cfg_len_en | input | 1 | Length byte enable |
| cfg_pay_len | input | PAY_LEN_W | Payload byte count |
| cfg_crc_en | input | 1 | CRC enable |
| cfg_crc_sel | input | 1 | CRC polynomial select |
| fifo_data | input | 8 | Head byte of the payload FIFO |
| fifo_rd | output | 1 | Payload FIFO pop |
| tx_bit | output | 1 | Serial bit |
| tx_valid | output | 1 | Strobe marking a new bit on tx_bit |
| busy | output | 1 | Packet in progress |
| done | output | 1 | End-of-packet pulse |

## Verification
The bench targets the field seams: a one-byte preamble, the full 256-byte preamble, every sync length code including the duplicate code 3, and sync words whose first and last bits vary. A design with the wrong preamble phase or trailer phase shows mismatches at the first bit of the affected field. The bench also covers an empty payload with and without CRC, and the 255-byte payload. A read issued one bit late or early shows up as a wrong recorded read position, or as payload bytes shifted by one. Runs with both polynomials and with and without the extended address catch a CRC that covers the wrong span or uses the wrong polynomial. A restart and a configuration change in mid-packet check that a block which re-arms or samples live configuration corrupts the stream.

// File: rtl/pft_pkg.sv
package pft_pkg;

    typedef enum logic [2:0] {
        FLD_IDLE,
        FLD_PRE,
        FLD_SYNC,
        FLD_TRL,
        FLD_HDR,
        FLD_LEN,
        FLD_PAY,
        FLD_CRC
    } field_e;

    localparam int SYNC_MAX_BYTES = 8;
    localparam int SYNC_W         = SYNC_MAX_BYTES * 8;
    localparam int TRL_BITS       = 4;
    localparam int ADDR_W         = 14;
    localparam int PID_W          = 2;
    localparam int CRC_W          = 16;
    localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
    localparam logic [CRC_W-1:0] POLY_A     = 16'h1021;
    localparam logic [CRC_W-1:0] POLY_B     = 16'h8005;

    // Per-bit view of where the sequencer stands
    typedef struct packed {
        logic   last;        // final bit of the current field
        logic   byte_end;    // final bit of a byte
        field_e tgt;         // field owning the next bit
        logic   hdr_second;  // next byte is the second header byte
    } step_t;

    function automatic logic carries_bytes(field_e f);
        return (f == FLD_HDR) || (f == FLD_LEN) || (f == FLD_PAY);
    endfunction

    function automatic int sync_bytes(logic [1:0] code);
        case (code)
            2'd0:    return 4;
            2'd1:    return 6;
            default: return SYNC_MAX_BYTES;
        endcase
    endfunction

    function automatic field_e next_field(field_e f, logic hdr_en, logic len_en,
                                          logic pay_nz, logic crc_en);
        field_e after_pay;
        field_e after_len;
        field_e after_hdr;
        after_pay = crc_en ? FLD_CRC : FLD_IDLE;
        after_len = pay_nz ? FLD_PAY : after_pay;
        after_hdr = len_en ? FLD_LEN : after_len;
        case (f)
            FLD_PRE:  return FLD_SYNC;
            FLD_SYNC: return FLD_TRL;
            FLD_TRL:  return hdr_en ? FLD_HDR : after_hdr;
            FLD_HDR:  return after_hdr;
            FLD_LEN:  return after_len;
            FLD_PAY:  return after_pay;
            default:  return FLD_IDLE;
        endcase
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b, logic sel);
        logic [CRC_W-1:0] n;
        n = {c[CRC_W-2:0], 1'b0};
        if (c[CRC_W-1] ^ b)
            n = n ^ (sel ? POLY_B : POLY_A);
        return n;
    endfunction

endpackage

// File: rtl/pft_seq.sv
module pft_seq
    import pft_pkg::*;
#(
    parameter int PRE_LEN_W = 8,
    parameter int PAY_LEN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 bit_en,
    input  logic [PRE_LEN_W-1:0] cfg_pre_len,
    input  logic [1:0]           cfg_sync_len,
    input  logic                 cfg_hdr_en,
    input  logic                 cfg_addr_ext,
    input  logic                 cfg_len_en,
    input  logic [PAY_LEN_W-1:0] cfg_pay_len,
    input  logic                 cfg_crc_en,
    output field_e               fld,
    output logic                 accept,
    output logic                 emit,
    output step_t                step,
    output logic [PAY_LEN_W-1:0] pay_len_q,
    output logic                 done
);

    localparam int LEN_MAX_W = (PRE_LEN_W > PAY_LEN_W) ? PRE_LEN_W : PAY_LEN_W;
    localparam int CNT_W     = (LEN_MAX_W + 3 > 6) ? LEN_MAX_W + 3 : 6;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nlen;
    logic [1:0]       sync_len_q;
    logic             hdr_en_q;
    logic             ext_q;
    logic             len_en_q;
    logic             crc_en_q;
    logic             busy_i;
    field_e           nxt;

    assign busy_i = (fld != FLD_IDLE);
    assign accept = start & ~busy_i;
    assign emit   = busy_i & bit_en;

    always_comb begin
        nxt = next_field(fld, hdr_en_q, len_en_q, pay_len_q != '0, crc_en_q);
    end

    always_comb begin
        step.last       = (cnt == '0);
        step.byte_end   = (cnt[2:0] == 3'd0);
        step.tgt        = step.last ? nxt : fld;
        step.hdr_second = (fld == FLD_HDR) && !step.last;
    end

    // Bit count minus one of the field entered next
    always_comb begin
        case (nxt)
            FLD_SYNC: nlen = CNT_W'(sync_bytes(sync_len_q) * 8 - 1);
            FLD_TRL:  nlen = CNT_W'(TRL_BITS - 1);
            FLD_HDR:  nlen = ext_q ? CNT_W'(15) : CNT_W'(7);
            FLD_LEN:  nlen = CNT_W'(7);
            FLD_PAY:  nlen = CNT_W'({pay_len_q, 3'b000}) - CNT_W'(1);
            FLD_CRC:  nlen = CNT_W'(CRC_W - 1);
            default:  nlen = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            fld        <= FLD_IDLE;
            cnt        <= '0;
            sync_len_q <= '0;
            hdr_en_q   <= 1'b0;
            ext_q      <= 1'b0;
            len_en_q   <= 1'b0;
            pay_len_q  <= '0;
            crc_en_q   <= 1'b0;
        end else if (accept) begin
            fld        <= FLD_PRE;
            cnt        <= CNT_W'({cfg_pre_len, 3'b111});
            sync_len_q <= cfg_sync_len;
            hdr_en_q   <= cfg_hdr_en;
            ext_q      <= cfg_addr_ext;
            len_en_q   <= cfg_len_en;
            pay_len_q  <= cfg_pay_len;
            crc_en_q   <= cfg_crc_en;
        end else if (emit) begin
            if (step.last) begin
                fld <= nxt;
                cnt <= nlen;
                if (nxt == FLD_IDLE)
                    done <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R10: a start seen mid-packet leaves the sequencer untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_i && start && !bit_en) |=> ($stable(fld) && $stable(cnt)));

    // R11: done never lasts two cycles
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the CRC field never spans more than sixteen bits
    a_r9_crc_window: assert property (@(posedge clk) disable iff (rst)
        (fld == FLD_CRC) |-> (cnt < CNT_W'(CRC_W)));

endmodule

// File: rtl/pft_crc16.sv
module pft_crc16
    import pft_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   cfg_crc_sel,
    input  logic   emit,
    input  field_e fld,
    input  logic   bit_in,
    output logic   crc_msb
);

    logic [CRC_W-1:0] crc;
    logic             sel_q;

    assign crc_msb = crc[CRC_W-1];

    // Accumulates over byte fields, then drains itself during the CRC field
    always_ff @(posedge clk) begin
        if (rst) begin
            crc   <= '0;
            sel_q <= 1'b0;
        end else if (accept) begin
            crc   <= CRC_PRESET;
            sel_q <= cfg_crc_sel;
        end else if (emit) begin
            if (carries_bytes(fld))
                crc <= crc_step(crc, bit_in, sel_q);
            else if (fld == FLD_CRC)
                crc <= {crc[CRC_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/pft_bitsrc.sv
module pft_bitsrc
    import pft_pkg::*;
#(
    parameter int PAY_LEN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic [SYNC_W-1:0]    cfg_sync_word,
    input  logic [PID_W-1:0]     cfg_pid,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 emit,
    input  field_e               fld,
    input  step_t                step,
    input  logic [PAY_LEN_W-1:0] pay_len_q,
    input  logic [7:0]           fifo_data,
    input  logic                 crc_bit,
    output logic                 cur_bit,
    output logic                 fifo_rd
);

    logic [SYNC_W-1:0] sync_sr;
    logic [7:0]        byte_sr;
    logic [7:0]        next_byte;
    logic              alt;
    logic              load_byte;
    logic [PID_W-1:0]  pid_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        case (fld)
            FLD_PRE, FLD_TRL:          cur_bit = alt;
            FLD_SYNC:                  cur_bit = sync_sr[SYNC_W-1];
            FLD_HDR, FLD_LEN, FLD_PAY: cur_bit = byte_sr[7];
            FLD_CRC:                   cur_bit = crc_bit;
            default:                   cur_bit = 1'b0;
        endcase
    end

    assign load_byte = emit && step.byte_end && carries_bytes(step.tgt);
    assign fifo_rd   = load_byte && (step.tgt == FLD_PAY);

    always_comb begin
        case (step.tgt)
            FLD_HDR: next_byte = step.hdr_second ? addr_q[ADDR_W-1:6]
                                                 : {pid_q, addr_q[5:0]};
            FLD_LEN: next_byte = 8'(pay_len_q);
            default: next_byte = fifo_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_sr <= '0;
            byte_sr <= '0;
            alt     <= 1'b0;
            pid_q   <= '0;
            addr_q  <= '0;
        end else if (accept) begin
            sync_sr <= cfg_sync_word;
            alt     <= ~cfg_sync_word[SYNC_W-1];
            pid_q   <= cfg_pid;
            addr_q  <= cfg_addr;
            byte_sr <= '0;
        end else if (emit) begin
            if (fld == FLD_SYNC)
                sync_sr <= {sync_sr[SYNC_W-2:0], 1'b0};
            if (fld == FLD_SYNC && step.last)
                alt <= ~sync_sr[SYNC_W-1];
            else
                alt <= ~alt;
            if (load_byte)
                byte_sr <= next_byte;
            else
                byte_sr <= {byte_sr[6:0], 1'b0};
        end
    end

    // R3: preamble bits alternate
    a_r3_pre_alternates: assert property (@(posedge clk) disable iff (rst)
        (emit && fld == FLD_PRE && !step.last) |=> (cur_bit != $past(cur_bit)));

    // R5: trailer bits alternate
    a_r5_trl_alternates: assert property (@(posedge clk) disable iff (rst)
        (emit && fld == FLD_TRL && !step.last) |=> (cur_bit != $past(cur_bit)));

    // R8: every FIFO pop feeds the payload field
    a_r8_read_feeds_payload: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> (fld == FLD_PAY));

endmodule

// File: rtl/pkt_framer_tx.sv
module pkt_framer_tx
    import pft_pkg::*;
#(
    parameter int PRE_LEN_W = 8,
    parameter int PAY_LEN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 bit_en,
    input  logic [PRE_LEN_W-1:0] cfg_pre_len,
    input  logic [1:0]           cfg_sync_len,
    input  logic [SYNC_W-1:0]    cfg_sync_word,
    input  logic                 cfg_hdr_en,
    input  logic [PID_W-1:0]     cfg_pid,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_addr_ext,
    input  logic                 cfg_len_en,
    input  logic [PAY_LEN_W-1:0] cfg_pay_len,
    input  logic                 cfg_crc_en,
    input  logic                 cfg_crc_sel,
    input  logic [7:0]           fifo_data,
    output logic                 fifo_rd,
    output logic                 tx_bit,
    output logic                 tx_valid,
    output logic                 busy,
    output logic                 done
);

    field_e               fld;
    step_t                step;
    logic                 accept;
    logic                 emit;
    logic                 cur_bit;
    logic                 crc_bit;
    logic [PAY_LEN_W-1:0] pay_len_q;

    pft_seq #(
        .PRE_LEN_W (PRE_LEN_W),
        .PAY_LEN_W (PAY_LEN_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .bit_en       (bit_en),
        .cfg_pre_len  (cfg_pre_len),
        .cfg_sync_len (cfg_sync_len),
        .cfg_hdr_en   (cfg_hdr_en),
        .cfg_addr_ext (cfg_addr_ext),
        .cfg_len_en   (cfg_len_en),
        .cfg_pay_len  (cfg_pay_len),
        .cfg_crc_en   (cfg_crc_en),
        .fld          (fld),
        .accept       (accept),
        .emit         (emit),
        .step         (step),
        .pay_len_q    (pay_len_q),
        .done         (done)
    );

    pft_bitsrc #(
        .PAY_LEN_W (PAY_LEN_W)
    ) u_bitsrc (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .cfg_sync_word (cfg_sync_word),
        .cfg_pid       (cfg_pid),
        .cfg_addr      (cfg_addr),
        .emit          (emit),
        .fld           (fld),
        .step          (step),
        .pay_len_q     (pay_len_q),
        .fifo_data     (fifo_data),
        .crc_bit       (crc_bit),
        .cur_bit       (cur_bit),
        .fifo_rd       (fifo_rd)
    );

    pft_crc16 u_crc (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .cfg_crc_sel (cfg_crc_sel),
        .emit        (emit),
        .fld         (fld),
        .bit_in      (cur_bit),
        .crc_msb     (crc_bit)
    );

    assign busy = (fld != FLD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_bit   <= 1'b0;
        end else begin
            tx_valid <= emit;
            if (emit)
                tx_bit <= cur_bit;
        end
    end

    // R2: a strobe only ever follows a bit-rate enable
    a_r2_strobe_follows_enable: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bit_en));

    // R11: done coincides with the final strobe and the end of busy
    a_r11_done_with_last: assert property (@(posedge clk) disable iff (rst)
        done |-> (tx_valid && !busy));

endmodule

// File: tb/test_pkt_framer_tx.sv
`timescale 1ns/1ps
module test_pkt_framer_tx;

    localparam int PRE_LEN_W = 8;
    localparam int PAY_LEN_W = 8;
    localparam int NCASE     = 7;
    localparam int MAXB      = 2300;

    typedef struct packed {
        logic [7:0]  pre;
        logic [1:0]  sl;
        logic        hdr;
        logic        ext;
        logic        len;
        logic [7:0]  pay;
        logic        crc;
        logic        sel;
        logic [2:0]  per;
        logic [11:0] nbits;
        logic [63:0] sync;
    } case_t;

    localparam case_t CASES [NCASE] = '{
        '{8'd0,   2'd0, 1'b0, 1'b0, 1'b0, 8'd2,   1'b0, 1'b0, 3'd1, 12'd60,   64'h3C96_0F1E_A5A5_5A5A},
        '{8'd1,   2'd1, 1'b1, 1'b0, 1'b1, 8'd3,   1'b1, 1'b0, 3'd2, 12'd124,  64'hB4E1_77C3_0A9D_F00D},
        '{8'd3,   2'd2, 1'b1, 1'b1, 1'b1, 8'd4,   1'b1, 1'b1, 3'd3, 12'd172,  64'h5A3C_C3A5_9617_E2B1},
        '{8'd0,   2'd0, 1'b0, 1'b0, 1'b0, 8'd0,   1'b1, 1'b0, 3'd1, 12'd60,   64'hF00F_1234_8888_7777},
        '{8'd255, 2'd2, 1'b0, 1'b0, 1'b0, 8'd1,   1'b0, 1'b0, 3'd1, 12'd2124, 64'h0123_4567_89AB_CDEF},
        '{8'd2,   2'd3, 1'b1, 1'b1, 1'b0, 8'd255, 1'b1, 1'b1, 3'd2, 12'd2164, 64'hC001_D00D_BEEF_0F0E},
        '{8'd0,   2'd0, 1'b0, 1'b0, 1'b0, 8'd0,   1'b0, 1'b0, 3'd4, 12'd44,   64'h6E6E_1B1B_0000_0000}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic                 bit_en = 1'b0;
    logic [PRE_LEN_W-1:0] cfg_pre_len = '0;
    logic [1:0]           cfg_sync_len = '0;
    logic [63:0]          cfg_sync_word = '0;
    logic                 cfg_hdr_en = 1'b0;
    logic [1:0]           cfg_pid = '0;
    logic [13:0]          cfg_addr = '0;
    logic                 cfg_addr_ext = 1'b0;
    logic                 cfg_len_en = 1'b0;
    logic [PAY_LEN_W-1:0] cfg_pay_len = '0;
    logic                 cfg_crc_en = 1'b0;
    logic                 cfg_crc_sel = 1'b0;
    logic [7:0]           fifo_data;
    logic                 fifo_rd;
    logic                 tx_bit;
    logic                 tx_valid;
    logic                 busy;
    logic                 done;

    int tests = 0;
    int fails = 0;

    bit   exp_bits [MAXB];
    bit   cap_bits [MAXB];
    int   exp_n;
    int   cap_n;
    int   pay_start;
    int   bnd [8];
    int   rd_pos [300];
    int   rd_n;
    int   done_n;
    bit   done_with_valid;
    logic [7:0] fifo_mem [256];
    int   rd_ptr = 0;
    int   period = 1;
    bit   gen_on = 1'b0;
    int   phase = 0;

    always #2 clk = ~clk;

    assign fifo_data = fifo_mem[rd_ptr[7:0]];

    pkt_framer_tx #(
        .PRE_LEN_W (PRE_LEN_W),
        .PAY_LEN_W (PAY_LEN_W)
    ) i_pkt_framer_tx (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .bit_en        (bit_en),
        .cfg_pre_len   (cfg_pre_len),
        .cfg_sync_len  (cfg_sync_len),
        .cfg_sync_word (cfg_sync_word),
        .cfg_hdr_en    (cfg_hdr_en),
        .cfg_pid       (cfg_pid),
        .cfg_addr      (cfg_addr),
        .cfg_addr_ext  (cfg_addr_ext),
        .cfg_len_en    (cfg_len_en),
        .cfg_pay_len   (cfg_pay_len),
        .cfg_crc_en    (cfg_crc_en),
        .cfg_crc_sel   (cfg_crc_sel),
        .fifo_data     (fifo_data),
        .fifo_rd       (fifo_rd),
        .tx_bit        (tx_bit),
        .tx_valid      (tx_valid),
        .busy          (busy),
        .done          (done)
    );

    // Bit-rate enable generator
    initial forever begin
        @(negedge clk);
        phase = (phase + 1 >= period) ? 0 : phase + 1;
        bit_en <= gen_on && (phase == 0);
    end

    // FIFO pop model
    initial forever begin
        @(posedge clk);
        if (fifo_rd) rd_ptr <= rd_ptr + 1;
    end

    // Output monitor
    initial forever begin
        @(negedge clk);
        if (tx_valid) begin
            if (cap_n < MAXB) cap_bits[cap_n] = tx_bit;
            cap_n++;
        end
        if (fifo_rd) begin
            if (rd_n < 300) rd_pos[rd_n] = cap_n;
            rd_n++;
        end
        if (done) begin
            done_n++;
            done_with_valid = tx_valid;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] d, logic sel);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[15] ^ d[i];
            c  = c << 1;
            if (fb) c = c ^ (sel ? 16'h8005 : 16'h1021);
        end
        return c;
    endfunction

    task automatic push(input bit b);
        if (exp_n < MAXB) exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic push_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) push(d[i]);
    endtask

    task automatic build_expected();
        int nb;
        logic [15:0] crc;
        bit first;
        exp_n = 0;
        crc   = 16'hFFFF;
        bnd[0] = 0;
        first = ~cfg_sync_word[63];
        for (int i = 0; i < 8 * (int'(cfg_pre_len) + 1); i++) push(first ^ i[0]);
        bnd[1] = exp_n;
        nb = (cfg_sync_len == 2'd0) ? 4 : (cfg_sync_len == 2'd1) ? 6 : 8;
        for (int i = 0; i < 8 * nb; i++) push(cfg_sync_word[63 - i]);
        bnd[2] = exp_n;
        first = ~cfg_sync_word[64 - 8 * nb];
        for (int i = 0; i < 4; i++) push(first ^ i[0]);
        bnd[3] = exp_n;
        if (cfg_hdr_en) begin
            push_byte({cfg_pid, cfg_addr[5:0]});
            crc = crc_byte(crc, {cfg_pid, cfg_addr[5:0]}, cfg_crc_sel);
            if (cfg_addr_ext) begin
                push_byte(cfg_addr[13:6]);
                crc = crc_byte(crc, cfg_addr[13:6], cfg_crc_sel);
            end
        end
        bnd[4] = exp_n;
        if (cfg_len_en) begin
            push_byte(cfg_pay_len);
            crc = crc_byte(crc, cfg_pay_len, cfg_crc_sel);
        end
        bnd[5] = exp_n;
        pay_start = exp_n;
        for (int k = 0; k < int'(cfg_pay_len); k++) begin
            push_byte(fifo_mem[k]);
            crc = crc_byte(crc, fifo_mem[k], cfg_crc_sel);
        end
        bnd[6] = exp_n;
        if (cfg_crc_en)
            for (int i = 15; i >= 0; i--) push(crc[i]);
        bnd[7] = exp_n;
    endtask

    task automatic cmp_range(input string req, input int lo, input int hi);
        int bad = 0;
        int first_bad = -1;
        for (int i = lo; i < hi && i < MAXB; i++) begin
            if (i >= cap_n || cap_bits[i] != exp_bits[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0)
            check(1'b0, req, int'(cap_bits[first_bad]), int'(exp_bits[first_bad]));
        else
            check(1'b1, req, 0, 0);
    endtask

    task automatic apply_case(input int idx);
        case_t c;
        c = CASES[idx];
        cfg_pre_len   = c.pre;
        cfg_sync_len  = c.sl;
        cfg_sync_word = c.sync;
        cfg_hdr_en    = c.hdr;
        cfg_addr_ext  = c.ext;
        cfg_len_en    = c.len;
        cfg_pay_len   = c.pay;
        cfg_crc_en    = c.crc;
        cfg_crc_sel   = c.sel;
        cfg_pid       = 2'(idx) ^ 2'b10;
        cfg_addr      = 14'(14'h1A53 + idx * 801);
        period        = int'(c.per);
        for (int k = 0; k < 256; k++) fifo_mem[k] = 8'(k * 37 + idx * 11 + 5);
    endtask

    task automatic launch();
        rd_ptr = 0;
        cap_n  = 0;
        rd_n   = 0;
        done_n = 0;
        done_with_valid = 1'b0;
        build_expected();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic field_checks();
        string tags [7];
        int rd_bad;
        tags = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9"};
        for (int f = 0; f < 7; f++)
            if (bnd[f + 1] > bnd[f]) cmp_range(tags[f], bnd[f], bnd[f + 1]);
        rd_bad = 0;
        for (int k = 0; k < rd_n && k < 300; k++)
            if (rd_pos[k] != pay_start + 8 * k - 1) rd_bad++;
        check(rd_n == int'(cfg_pay_len) && rd_bad == 0, "R8 fifo_rd count/position",
              rd_n * 1000 + rd_bad, int'(cfg_pay_len) * 1000);
        check(done_n == 1 && done_with_valid, "R11 done pulse",
              done_n * 10 + int'(done_with_valid), 11);
    endtask

    initial begin
        // R1: reset state
        gen_on = 1'b1;
        period = 1;
        repeat (4) @(negedge clk);
        check(!busy && !tx_valid && !done && !fifo_rd, "R1 in reset",
              {busy, tx_valid, done, fifo_rd}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !tx_valid && !done && !fifo_rd, "R1 after reset",
              {busy, tx_valid, done, fifo_rd}, 0);

        // R2: idle with the enable running emits nothing
        cap_n = 0;
        rd_n  = 0;
        repeat (20) @(negedge clk);
        check(cap_n == 0 && rd_n == 0, "R2 idle silent", cap_n + rd_n, 0);

        // Table-driven packets
        for (int idx = 0; idx < NCASE; idx++) begin
            @(negedge clk);
            apply_case(idx);
            launch();
            while (done_n == 0) @(negedge clk);
            repeat (4) @(negedge clk);
            check(cap_n == exp_n && exp_n == int'(CASES[idx].nbits), "R2 packet length",
                  cap_n, int'(CASES[idx].nbits));
            field_checks();
        end

        // R10: restart and config change mid-packet
        @(negedge clk);
        apply_case(2);
        period = 1;
        launch();
        while (cap_n < 40) @(negedge clk);
        cfg_pre_len   = 8'd7;
        cfg_sync_word = ~cfg_sync_word;
        cfg_hdr_en    = 1'b0;
        cfg_pay_len   = 8'd9;
        cfg_crc_sel   = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_n == 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(cap_n == exp_n, "R10 length unchanged", cap_n, exp_n);
        cmp_range("R10 stream unchanged", 0, exp_n);
        check(rd_n == 4 && done_n == 1, "R10 reads/done", rd_n * 10 + done_n, 41);
        repeat (40) @(negedge clk);
        check(cap_n == exp_n && !busy, "R10 no second packet", cap_n, exp_n);

        summary();
        $finish;
    end

endmodule